// File: doc/BRIEF.md
# Serial Register Loader with Address-Routed Latches

This block takes configuration words over a three-wire serial link (serial clock, serial data, load strobe) and places each word into one of four parallel holding latches. Bits arrive most significant first and enter a 24-bit shift register on every rising edge of the serial clock. A rising edge on the load strobe commits the shifted word. The two least significant bits of the word carry the destination address. The remaining 22 bits are the payload that is stored.

All three serial pins are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the clock and load pins then go through rising-edge detection. The four latches are visible as parallel buses. Two of them are also shown as decoded fields: a 14-bit reference divider value, and a feedback divider split into a 5-bit A field and a 13-bit B field. A one-cycle update pulse marks each latch write, so downstream logic can act on a new feedback divider word. The fourth destination is reserved for factory test. It accepts writes only while the test-enable input is high.

The serial link has no flow control, so there is no back-pressure. The sender must space serial clock edges at least three system-clock cycles apart, and the receiver never stalls. Each update pulse is a single-cycle event with no ready handshake.

Top module: `serial_latch_loader`

## Requirements
- R1: After reset, all four latches read zero and all update pulses are low.
- R2: Each synchronized rising edge of `ser_clk` shifts the synchronized `ser_data` bit into the LSB of the shift register, and earlier bits move toward the MSB. With no such edge, the register holds its value.
- R3: A rising edge of `ser_load` writes word bits [23:2] to the latch addressed by word bits [1:0]: 00 control, 01 reference divider, 10 feedback divider, 11 test.
- R4: A write leaves the latches that it does not address unchanged.
- R5: Each accepted write raises exactly one bit of `upd`, for one system-clock cycle. The bit index equals the address. The pulse appears after the third rising system-clock edge that follows the rise of `ser_load`.
- R6: A write addressed to the test latch (address 11) while `test_en` is low does not change `test_q` and raises no `upd` bit.
- R7: A write addressed to the test latch while `test_en` is high is stored and pulses `upd[3]`.
- R8: `r_div` equals bits [15:2] of the last word written to the reference divider latch.
- R9: `n_a` equals bits [6:2] and `n_b` equals bits [20:8] of the last word written to the feedback divider latch.
- R10: When more than 24 bits are shifted before a load, only the last 24 bits are used.
- R11: If `ser_load` is held high, only one write happens. No further write occurs until `ser_load` falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first, asynchronous |
| ser_load | input | 1 | Load strobe; its rising edge commits the word |
| test_en | input | 1 | Permits writes to the test latch |
| ctrl_q | output | 22 | Control latch payload |
| rdiv_q | output | 22 | Reference divider latch payload |
| ndiv_q | output | 22 | Feedback divider latch payload |
| test_q | output | 22 | Test latch payload |
| r_div | output | 14 | Reference divider value |
| n_a | output | 5 | Feedback divider A field |
| n_b | output | 13 | Feedback divider B field |
| upd | output | 4 | One-cycle write pulse, one bit per latch |

## Verification
A rise of `ser_load` reaches the latches and `upd` after three system-clock edges: two synchronizer stages, then the registered write. The bench raises the strobe just after a falling edge, waits three rising edges, and samples on the falling edge that follows. It then checks on the next falling edge that the pulse is gone. Serial data is set three cycles before each `ser_clk` rise and held for seven cycles. This delay matches the clock path, so every bit is captured in the right position. The decoded divider fields are combinational views of the latches, so they are checked at the same sample point as the latches.

// File: rtl/sll_pkg.sv
package sll_pkg;
  localparam int ADDR_W = 2;
  localparam int N_DEST = 4;

  typedef enum logic [ADDR_W-1:0] {
    DST_CTRL = 2'b00,
    DST_RDIV = 2'b01,
    DST_NDIV = 2'b10,
    DST_TEST = 2'b11
  } dest_e;
endpackage

// File: rtl/sll_sync.sv
module sll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      prev  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R11
endmodule

// File: rtl/sll_shifter.sv
module sll_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word)); // R2
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> word[WORD_W-1:1] == $past(word[WORD_W-2:0])); // R2
endmodule

// File: rtl/sll_latch_bank.sv
module sll_latch_bank
  import sll_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int PAY_W = WORD_W - ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [WORD_W-1:0]             word,
  input  logic                          test_en,
  output logic [N_DEST-1:0][PAY_W-1:0]  latch_q,
  output logic [N_DEST-1:0]             upd
);
  dest_e addr;
  assign addr = dest_e'(word[ADDR_W-1:0]);

  for (genvar g = 0; g < N_DEST; g++) begin : g_latch
    logic allowed;
    logic hit;
    assign allowed = (g != int'(DST_TEST)) || test_en;
    assign hit     = wr && (addr == dest_e'(g)) && allowed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[g] <= '0;
        upd[g]     <= 1'b0;
      end else begin
        upd[g] <= hit;
        if (hit) latch_q[g] <= word[WORD_W-1:ADDR_W];
      end
    end
  end

  AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd)); // R5
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd != '0) |=> (upd == '0)); // R5
  AST_TEST_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == DST_TEST && !test_en) |=> ($stable(latch_q[DST_TEST]) && upd == '0)); // R6
  AST_UNSEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != DST_CTRL) |=> $stable(latch_q[DST_CTRL])); // R4
endmodule

// File: rtl/serial_latch_loader.sv
module serial_latch_loader
  import sll_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 24,
  parameter int R_W         = 14,
  parameter int A_W         = 5,
  parameter int B_W         = 13,
  localparam int PAY_W      = WORD_W - ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_load,
  input  logic             test_en,
  output logic [PAY_W-1:0] ctrl_q,
  output logic [PAY_W-1:0] rdiv_q,
  output logic [PAY_W-1:0] ndiv_q,
  output logic [PAY_W-1:0] test_q,
  output logic [R_W-1:0]   r_div,
  output logic [A_W-1:0]   n_a,
  output logic [B_W-1:0]   n_b,
  output logic [3:0]       upd
);
  // B field starts one bit above A, leaving a reserved gap bit
  localparam int B_LSB = A_W + 1;

  logic                         sclk_lvl, sclk_rise;
  logic                         sdat_lvl, sdat_rise;
  logic                         load_lvl, load_rise;
  logic [WORD_W-1:0]            word;
  logic [N_DEST-1:0][PAY_W-1:0] latch_q;

  sll_sync #(.STAGES(SYNC_STAGES)) i_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(ser_clk), .lvl(sclk_lvl), .rise(sclk_rise));
  sll_sync #(.STAGES(SYNC_STAGES)) i_sync_dat (
    .clk(clk), .rst_n(rst_n), .d(ser_data), .lvl(sdat_lvl), .rise(sdat_rise));
  sll_sync #(.STAGES(SYNC_STAGES)) i_sync_load (
    .clk(clk), .rst_n(rst_n), .d(ser_load), .lvl(load_lvl), .rise(load_rise));

  sll_shifter #(.WORD_W(WORD_W)) i_shifter (
    .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .bit_in(sdat_lvl), .word(word));

  sll_latch_bank #(.WORD_W(WORD_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr(load_rise), .word(word), .test_en(test_en),
    .latch_q(latch_q), .upd(upd));

  assign ctrl_q = latch_q[DST_CTRL];
  assign rdiv_q = latch_q[DST_RDIV];
  assign ndiv_q = latch_q[DST_NDIV];
  assign test_q = latch_q[DST_TEST];

  assign r_div = rdiv_q[R_W-1:0];
  assign n_a   = ndiv_q[A_W-1:0];
  assign n_b   = ndiv_q[B_LSB +: B_W];

  logic unused_lvls;
  assign unused_lvls = sclk_lvl ^ sdat_rise ^ load_lvl;

  AST_LOAD_TO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd != '0) |-> $past(load_rise)); // R5
endmodule

// File: tb/test_serial_latch_loader.sv
module test_serial_latch_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, test_en = 1'b0;
  logic [21:0] ctrl_q, rdiv_q, ndiv_q, test_q;
  logic [13:0] r_div;
  logic [4:0]  n_a;
  logic [12:0] n_b;
  logic [3:0]  upd;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  logic [21:0] e_ctrl = '0, e_rdiv = '0, e_ndiv = '0, e_test = '0;
  logic [23:0] last_r = '0, last_n = '0;

  always #5 clk = ~clk;

  serial_latch_loader i_serial_latch_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .test_en(test_en), .ctrl_q(ctrl_q), .rdiv_q(rdiv_q),
    .ndiv_q(ndiv_q), .test_q(test_q), .r_div(r_div), .n_a(n_a), .n_b(n_b),
    .upd(upd));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] val, input int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk) ser_data = val[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic check_latches(input string req);
    chk(ctrl_q == e_ctrl, req, ctrl_q, e_ctrl);
    chk(rdiv_q == e_rdiv, req, rdiv_q, e_rdiv);
    chk(ndiv_q == e_ndiv, req, ndiv_q, e_ndiv);
    chk(test_q == e_test, req, test_q, e_test);
  endtask

  // Raise load, sample the pulse after three rising edges, then the clear.
  task automatic do_load(input logic [3:0] exp_upd, input int hold, input string req);
    @(negedge clk) ser_load = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(upd == exp_upd, req, upd, exp_upd);
    check_latches(req);
    @(negedge clk);
    chk(upd == 4'b0, req, upd, 4'b0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(upd == 4'b0, "R11 held load", upd, 4'b0);
    end
    ser_load = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check_latches("R1 reset latches");
    chk(upd == 4'b0, "R1 reset upd", upd, 4'b0);
  endtask

  task automatic t_ctrl;
    logic [23:0] w = 24'hA5C3F0;
    send_bits(32'(w), 24);
    e_ctrl = w[23:2];
    do_load(4'b0001, 0, "R3 R4 R5 control write");
  endtask

  task automatic t_rdiv;
    logic [23:0] w = 24'h9ABCD5;
    send_bits(32'(w), 24);
    e_rdiv = w[23:2];
    last_r = w;
    do_load(4'b0010, 0, "R3 R4 R5 rdiv write");
    chk(r_div == last_r[15:2], "R8 r_div", r_div, last_r[15:2]);
  endtask

  task automatic t_ndiv;
    logic [23:0] w = 24'hF1E2A6;
    send_bits(32'(w), 24);
    e_ndiv = w[23:2];
    last_n = w;
    do_load(4'b0100, 0, "R3 R4 R5 ndiv write");
    chk(n_a == last_n[6:2], "R9 n_a", n_a, last_n[6:2]);
    chk(n_b == last_n[20:8], "R9 n_b", n_b, last_n[20:8]);
  endtask

  task automatic t_test_blocked;
    logic [23:0] w = 24'h5A5A5B;
    test_en = 1'b0;
    send_bits(32'(w), 24);
    do_load(4'b0000, 0, "R6 test write blocked");
  endtask

  task automatic t_test_allowed;
    logic [23:0] w = 24'h3C3C3F;
    test_en = 1'b1;
    send_bits(32'(w), 24);
    e_test = w[23:2];
    do_load(4'b1000, 0, "R7 test write allowed");
    test_en = 1'b0;
  endtask

  task automatic t_overlong;
    logic [23:0] w = 24'h123455;
    send_bits(32'h2A, 6);
    send_bits(32'(w), 24);
    e_rdiv = w[23:2];
    last_r = w;
    do_load(4'b0010, 0, "R10 R2 overlong frame");
    chk(r_div == last_r[15:2], "R10 R8 r_div", r_div, last_r[15:2]);
  endtask

  task automatic t_load_held;
    logic [23:0] w = 24'h0F0F0E;
    send_bits(32'(w), 24);
    e_ndiv = w[23:2];
    last_n = w;
    do_load(4'b0100, 10, "R11 R5 held load");
    chk(n_b == last_n[20:8], "R11 R9 n_b", n_b, last_n[20:8]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl();
    t_rdiv();
    t_ndiv();
    t_test_blocked();
    t_test_allowed();
    t_overlong();
    t_load_held();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule